// File: doc/BRIEF.md
# Flash block write controller

This block manages programming of a word-addressed program flash through four write-only registers: an address register, a data register, a control register and a key register. Software loads an address and a data word, writes the two unlock bytes to the key register and then sets the start bit in the control register. That sequence is repeated for every word. Each accepted word goes into one slot of an eight-entry buffer. The slot is chosen by the low three address bits. Only the word whose offset is 7 starts a commit. A commit erases the aligned sixteen-word region to all ones and then programs the eight buffered words into the aligned eight-word block.

An accepted start always has a fixed setup of two cycles. During a commit, a stall output holds the CPU for a parameterized number of cycles while the clock keeps running. A two-bit protection level blocks starts aimed at protected quarters of the array. A small register-array model stands in for the flash, and it can be read combinationally for inspection.

The register port is a plain write strobe with no back-pressure: every write is taken in the cycle it is presented. A start that arrives while an operation is running is dropped, and the status outputs let software see this.

Top module: `flash_blk_wr`

## Requirements
- R1: A start is accepted only if the last two register writes before the control write went to the key register and carried 0x55 and then 0xAA. A key write with any other byte, or any write to the address or data register, clears the unlock progress.
- R2: A control write starts an operation only if its bit 0 (start) and bit 1 (program-memory select) are both 1. A request with bit 1 clear is ignored, and mem_sel reads back bit 1 of the last control write.
- R3: For a start whose address bits [2:0] are not 111, the word is latched into the buffer slot given by those bits. busy falls two cycles after the control-write edge, and cpu_stall never rises.
- R4: For a start at offset 111, cpu_stall rises two cycles after the control-write edge and stays high for ERASE_CYC cycles. It falls in the same cycle as busy.
- R5: A commit sets every word of the aligned sixteen-word region that contains the address to all ones. It then writes buffer slots 0..7 into the aligned eight-word block.
- R6: Buffer slots not loaded since the last commit keep their earlier contents and are programmed again.
- R7: With protection level P on wp_level, a start is ignored when the target's top two address bits, read as a number, are below P. With P=0 nothing is protected.
- R8: busy reads 1 from the cycle after an accepted control write until the operation completes.
- R9: After reset, busy and cpu_stall are 0 and every array word and buffer slot holds all ones.
- R10: Every word needs a fresh unlock. A start accepted once consumes the key, so a second start without new key writes is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 address, 1 data, 2 control, 3 key |
| reg_wdata | input | WORD_W | Write data (key uses bits [7:0]) |
| wp_level | input | 2 | Write-protection level |
| rd_addr | input | ADDR_W | Array inspection address |
| rd_data | output | WORD_W | Array word at rd_addr (combinational) |
| busy | output | 1 | Start bit readback, high while an operation runs |
| cpu_stall | output | 1 | Halts CPU instruction execution during a commit |
| mem_sel | output | 1 | Program-memory select readback |

## Verification
The control write lands at edge T. Acceptance shows on busy one cycle after T. An ordinary word finishes at edge T+2, and the stall of a commit begins at edge T+2. The stall ends, and the array holds the new contents, at edge T+2+ERASE_CYC. The bench drives on falling edges and samples on the falling edge just after each of these rising edges: it checks the stall still high one cycle before its end and low at its end. A reference array and buffer are updated in the bench at the same points and then compared word by word through the read port.

// File: rtl/fbw_pkg.sv
package fbw_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_ERASE} phase_e;
  typedef enum logic [1:0] {K_IDLE, K_HALF, K_ARMED} key_e;
  localparam logic [1:0] SEL_ADDR = 2'd0;
  localparam logic [1:0] SEL_DATA = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;
  localparam logic [1:0] SEL_KEY  = 2'd3;
  localparam logic [7:0] KEY_FIRST  = 8'h55;
  localparam logic [7:0] KEY_SECOND = 8'hAA;
endpackage

// File: rtl/fbw_unlock.sv
module fbw_unlock
  import fbw_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [1:0] wr_sel,
  input  logic [7:0] key_byte,
  output logic       armed
);
  key_e st_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= K_IDLE;
    end else if (wr_en) begin
      if (wr_sel == SEL_KEY) begin
        // any byte off the expected path drops back to idle
        if (st_q == K_IDLE && key_byte == KEY_FIRST)
          st_q <= K_HALF;
        else if (st_q == K_HALF && key_byte == KEY_SECOND)
          st_q <= K_ARMED;
        else
          st_q <= K_IDLE;
      end else begin
        // address, data and control writes all consume or break the unlock
        st_q <= K_IDLE;
      end
    end
  end

  assign armed = (st_q == K_ARMED);
endmodule

// File: rtl/fbw_seq.sv
module fbw_seq
  import fbw_pkg::*;
#(
  parameter int SETUP_CYC = 2,
  parameter int ERASE_CYC = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic go_i,
  input  logic commit_i,
  output logic busy_o,
  output logic stall_o,
  output logic latch_o,
  output logic erase_o,
  output logic prog_o
);
  localparam int MAXC = (SETUP_CYC > ERASE_CYC) ? SETUP_CYC : ERASE_CYC;
  localparam int CW = $clog2(MAXC + 1);
  localparam logic [CW-1:0] SET_LAST = CW'(SETUP_CYC - 1);
  localparam logic [CW-1:0] ERA_LAST = CW'(ERASE_CYC - 1);

  phase_e ph_q;
  logic [CW-1:0] cnt_q;
  logic commit_q;

  assign latch_o = (ph_q == PH_SETUP) && (cnt_q == SET_LAST);
  assign erase_o = latch_o && commit_q;
  assign prog_o  = (ph_q == PH_ERASE) && (cnt_q == ERA_LAST);
  assign busy_o  = (ph_q != PH_IDLE);
  assign stall_o = (ph_q == PH_ERASE);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q     <= PH_IDLE;
      cnt_q    <= '0;
      commit_q <= 1'b0;
    end else begin
      case (ph_q)
        PH_IDLE: if (go_i) begin
          ph_q     <= PH_SETUP;
          cnt_q    <= '0;
          commit_q <= commit_i;
        end
        PH_SETUP: begin
          if (cnt_q == SET_LAST) begin
            cnt_q <= '0;
            ph_q  <= commit_q ? PH_ERASE : PH_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_ERASE: begin
          if (cnt_q == ERA_LAST) begin
            cnt_q <= '0;
            ph_q  <= PH_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fbw_array.sv
module fbw_array #(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              latch_i,
  input  logic              erase_i,
  input  logic              prog_i,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [WORD_W-1:0] op_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int BLK = 8;
  localparam int REG = 16;

  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [WORD_W-1:0] buf_q [BLK];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < BLK; i++) buf_q[i] <= '1;
    end else if (latch_i) begin
      buf_q[op_addr[2:0]] <= op_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
    end else if (erase_i) begin
      for (int i = 0; i < REG; i++)
        mem_q[{op_addr[ADDR_W-1:4], 4'(i)}] <= '1;
    end else if (prog_i) begin
      for (int i = 0; i < BLK; i++)
        mem_q[{op_addr[ADDR_W-1:3], 3'(i)}] <= buf_q[i];
    end
  end

  assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/flash_blk_wr.sv
module flash_blk_wr
  import fbw_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int WORD_W    = 14,
  parameter int SETUP_CYC = 2,
  parameter int ERASE_CYC = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_en,
  input  logic [1:0]        reg_sel,
  input  logic [WORD_W-1:0] reg_wdata,
  input  logic [1:0]        wp_level,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data,
  output logic              busy,
  output logic              cpu_stall,
  output logic              mem_sel
);
  logic [ADDR_W-1:0] addr_q, op_addr_q;
  logic [WORD_W-1:0] data_q, op_data_q;
  logic armed, go, prot_hit, ctrl_wr, commit;
  logic latch, erase, prog;

  fbw_unlock u_key (
    .clk(clk), .rst(rst), .wr_en(reg_wr_en), .wr_sel(reg_sel),
    .key_byte(reg_wdata[7:0]), .armed(armed)
  );

  assign prot_hit = (addr_q[ADDR_W-1 -: 2] < wp_level);
  assign ctrl_wr  = reg_wr_en && (reg_sel == SEL_CTRL);
  assign go       = ctrl_wr && reg_wdata[0] && reg_wdata[1] && armed && !busy && !prot_hit;
  assign commit   = &addr_q[2:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q    <= '0;
      data_q    <= '0;
      op_addr_q <= '0;
      op_data_q <= '0;
      mem_sel   <= 1'b0;
    end else begin
      if (reg_wr_en && reg_sel == SEL_ADDR) addr_q <= reg_wdata[ADDR_W-1:0];
      if (reg_wr_en && reg_sel == SEL_DATA) data_q <= reg_wdata;
      if (ctrl_wr) mem_sel <= reg_wdata[1];
      if (go) begin
        op_addr_q <= addr_q;
        op_data_q <= data_q;
      end
    end
  end

  fbw_seq #(.SETUP_CYC(SETUP_CYC), .ERASE_CYC(ERASE_CYC)) u_seq (
    .clk(clk), .rst(rst), .go_i(go), .commit_i(commit),
    .busy_o(busy), .stall_o(cpu_stall), .latch_o(latch),
    .erase_o(erase), .prog_o(prog)
  );

  fbw_array #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_arr (
    .clk(clk), .rst(rst), .latch_i(latch), .erase_i(erase), .prog_i(prog),
    .op_addr(op_addr_q), .op_data(op_data_q),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // R1: an operation only begins after the tracker was armed
  p_start_keyed_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(armed));
  // R10: the accepting control write consumed the key
  p_key_consumed_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !armed);
  // R7: no operation begins toward a protected quarter
  p_prot_block_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !$past(prot_hit));
  // R2: an operation only begins with program memory selected
  p_memsel_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> mem_sel);
  // R4: the stall ends together with the operation
  p_stall_end_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(cpu_stall) |-> !busy);
endmodule

// File: tb/flash_blk_wr_test.sv
`timescale 1ns/1ps
module flash_blk_wr_test;
  localparam int AW = 6;
  localparam int WW = 14;
  localparam int E  = 16;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr_en = 1'b0;
  logic [1:0] reg_sel = '0;
  logic [WW-1:0] reg_wdata = '0;
  logic [1:0] wp_level = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [WW-1:0] rd_data;
  logic busy, cpu_stall, mem_sel;

  int ntests = 0;
  int nfail = 0;
  logic [WW-1:0] mdl [DEPTH];
  logic [WW-1:0] mbuf [8];

  always #2 clk = ~clk;

  flash_blk_wr #(.ADDR_W(AW), .WORD_W(WW), .SETUP_CYC(2), .ERASE_CYC(E)) uut (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .wp_level(wp_level), .rd_addr(rd_addr),
    .rd_data(rd_data), .busy(busy), .cpu_stall(cpu_stall), .mem_sel(mem_sel)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    ntests++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [WW-1:0] pat(input int a, input int salt);
    return WW'((a * 37 + 11 + salt * 113) ^ (a << 5));
  endfunction

  // called at a falling edge; returns at the falling edge after the write edge
  task automatic reg_wr(input logic [1:0] sel, input logic [WW-1:0] d);
    reg_wr_en = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic compare_all(input string tag);
    for (int i = 0; i < DEPTH; i++) begin
      rd_addr = AW'(i);
      #0.1;
      chk(tag, 32'(rd_data), 32'(mdl[i]));
    end
    @(negedge clk);
  endtask

  task automatic model_commit(input int a);
    for (int i = 0; i < 16; i++) mdl[(a & ~15) + i] = '1;
    for (int i = 0; i < 8; i++) mdl[(a & ~7) + i] = mbuf[i];
  endtask

  task automatic start_word(input int a, input logic [WW-1:0] d, input logic ok, input string tag);
    reg_wr(2'd0, WW'(a));
    reg_wr(2'd1, d);
    reg_wr(2'd3, WW'(8'h55));
    reg_wr(2'd3, WW'(8'hAA));
    reg_wr(2'd2, WW'(3));
    chk(tag, 32'(busy), 32'(ok));            // one cycle after write edge
    chk("R3 no early stall", 32'(cpu_stall), 0);
    if (ok) begin
      @(negedge clk);
      chk("R8 busy held", 32'(busy), 1);
      @(negedge clk);
      mbuf[a & 7] = d;
      if ((a & 7) != 7) begin
        chk("R3 done after setup", 32'(busy), 0);
        chk("R3 never stalls", 32'(cpu_stall), 0);
      end else begin
        chk("R4 stall after setup", 32'(cpu_stall), 1);
        repeat (E - 1) @(negedge clk);
        chk("R4 stall still high", 32'(cpu_stall), 1);
        @(negedge clk);
        chk("R4 stall end", 32'(cpu_stall), 0);
        chk("R4 busy end", 32'(busy), 0);
        model_commit(a);
      end
    end else begin
      @(negedge clk);
      chk(tag, 32'(busy), 0);
    end
  endtask

  initial begin
    #(4 * 200000);
    nfail++;
    $display("FAIL watchdog: got hang expected completion");
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) mdl[i] = '1;
    for (int i = 0; i < 8; i++) mbuf[i] = '1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 busy reset", 32'(busy), 0);
    chk("R9 stall reset", 32'(cpu_stall), 0);
    compare_all("R9 array ones");

    // R1: broken unlock patterns
    reg_wr(2'd0, WW'(5)); reg_wr(2'd1, WW'(123));
    reg_wr(2'd3, WW'(8'h55)); reg_wr(2'd3, WW'(8'h55)); reg_wr(2'd3, WW'(8'hAA));
    reg_wr(2'd2, WW'(3));
    chk("R1 repeated 55", 32'(busy), 0);
    reg_wr(2'd3, WW'(8'hAA)); reg_wr(2'd3, WW'(8'h55));
    reg_wr(2'd2, WW'(3));
    chk("R1 reversed key", 32'(busy), 0);
    reg_wr(2'd3, WW'(8'h55)); reg_wr(2'd0, WW'(5)); reg_wr(2'd3, WW'(8'hAA));
    reg_wr(2'd2, WW'(3));
    chk("R1 address write between", 32'(busy), 0);
    reg_wr(2'd3, WW'(8'h55)); reg_wr(2'd3, WW'(8'hAA)); reg_wr(2'd1, WW'(77));
    reg_wr(2'd2, WW'(3));
    chk("R1 data write after key", 32'(busy), 0);

    // R2: program-memory select clear
    reg_wr(2'd3, WW'(8'h55)); reg_wr(2'd3, WW'(8'hAA));
    reg_wr(2'd2, WW'(1));
    chk("R2 memsel clear ignored", 32'(busy), 0);
    chk("R2 memsel readback 0", 32'(mem_sel), 0);

    // R10: key is consumed by one start
    start_word(5, pat(5, 9), 1'b1, "R1 good unlock accepted");
    chk("R2 memsel readback 1", 32'(mem_sel), 1);
    reg_wr(2'd2, WW'(3));
    chk("R10 second start without key", 32'(busy), 0);
    @(negedge clk);
    chk("R10 still idle", 32'(busy), 0);
    compare_all("R2 array untouched");

    // R3/R4/R5: every block, every offset in ascending order
    for (int b = 0; b < 8; b++) begin
      for (int o = 0; o < 8; o++)
        start_word(b * 8 + o, pat(b * 8 + o, 0), 1'b1, "R8 word accepted");
      compare_all("R5 block commit");
    end

    // R6: only the final slot reloaded
    start_word(23, pat(23, 5), 1'b1, "R6 lone final word");
    compare_all("R6 stale slots reprogrammed");

    // R7: protection level versus target quarter
    for (int p = 0; p < 4; p++) begin
      wp_level = 2'(p);
      for (int q = 0; q < 4; q++)
        start_word(q * 16 + 7, pat(q * 16 + 7, p + 1), (q >= p), "R7 protection gate");
      compare_all("R7 array after protection pass");
    end

    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end
endmodule